// File: doc/BRIEF.md
# Dual-Sign Parity Error Detector

This block wraps a small combinational function (four inputs, six outputs, held in a lookup table) with concurrent error detection that uses two independent checks. The six outputs are compressed by a tree of two-input XOR nodes into one parity bit. The first check compares that parity with a bit predicted straight from the inputs, on every vector. The second check adds a correction term, computed only from the inputs, to the tree parity so that the result is a self-dual signal. That signal must take opposite values on a vector and on its bitwise inverse.

The block applies each operand twice. In the working phase it uses the operand as given. In the check phase it uses the operand inverted. An internal phase bit alternates every clock to drive this. The two checks each yield a two-rail pair, and a two-rail merging cell combines them into one indication (`err0`, `err1`). Complementary rails mean the computation was sound. Equal rails flag an error.

Each of the five tree nodes has an injection control that can force it to 0 or to 1. A bench can apply every operand exhaustively and count how often each fault is detected.

Top module: `dual_sign_ced`

## Requirements
- R1: `fn_out` equals the 6-bit table entry for the applied vector, where entry i sits at bits [6i+5:6i] of the table. The applied vector is `opnd` in phase 0 and `~opnd` in phase 1.
- R2: `chk_phase` is 0 during reset and in the first cycle after reset. After that it inverts on every rising clock edge.
- R3: The parity tree has five nodes: n0 = f0^f1, n1 = f2^f3, n2 = f4^f5, n3 = n0^n1, and n4 = n3^n2, which is the tree parity. Node k is controlled by `stuck_sel[2k+1:2k]`: 01 forces the node to 0, 10 forces it to 1, and 00 or 11 leaves it unforced.
- R4: With no node forced, `err0` and `err1` are always complementary. In phase 0, `err1` equals the tree parity. In phase 1, `err1` equals the tree parity of the inverted vector XOR the corrected parity captured in phase 0.
- R5: In any cycle where the tree parity differs from the parity predicted from the applied vector, `err0` equals `err1`.
- R6: The corrected parity of vector Y is the tree parity XOR a correction term d(Y). The term d(Y) is 0 when the top input bit of Y is 1. When that bit is 0, d(Y) = p(Y) XOR NOT p(~Y), where p is the fault-free parity. In phase 1, `err0` equals `err1` whenever the corrected parity of the inverted vector equals the corrected parity captured in phase 0.
- R7: In phase 0 the self-duality check contributes nothing. The rails agree only if the parity check of R5 fails.
- R8: Asserting reset mid-operation returns the block to phase 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opnd | input | 4 | Operand, held for both phases of a pair |
| stuck_sel | input | 10 | Two-bit force control per tree node |
| fn_out | output | 6 | Output of the protected function |
| chk_phase | output | 1 | 0 = operand applied as given, 1 = operand inverted |
| err0 | output | 1 | Two-rail error indication, rail 0 |
| err1 | output | 1 | Two-rail error indication, rail 1 |

## Verification
The hardest case to reach is a tree fault that corrupts the parity on both vectors of a pair. Such a fault leaves the self-dual signal alternating correctly, so only the per-vector parity check can catch it. To reach it, the stimulus forces each of the five nodes to each constant in turn and applies all sixteen operands as pairs. For every cycle it predicts from a reference model whether the parity check, the self-duality check, both or neither should fire. The check on the second vector of a pair depends on the value captured in the previous cycle, so the operand and the fault are held steady across both phases.

// File: rtl/dual_sign_ced.sv
module dual_sign_ced #(
  parameter int NIN = 4,
  parameter logic [(1<<NIN)*6-1:0] LUT = {
    6'h21, 6'h08, 6'h3f, 6'h14, 6'h2d, 6'h06, 6'h33, 6'h19,
    6'h0e, 6'h30, 6'h1a, 6'h27, 6'h05, 6'h3c, 6'h11, 6'h2b}
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NIN-1:0] opnd,
  input  logic [9:0]     stuck_sel,
  output logic [5:0]     fn_out,
  output logic           chk_phase,
  output logic           err0,
  output logic           err1
);
  localparam int NOUT = 6;
  localparam int NVEC = 1 << NIN;

  function automatic logic [NVEC-1:0] mk_pred();
    logic [NVEC-1:0] p;
    for (int i = 0; i < NVEC; i++) p[i] = ^LUT[i*NOUT +: NOUT];
    return p;
  endfunction

  localparam logic [NVEC-1:0] PRED = mk_pred();

  function automatic logic [NVEC-1:0] mk_delta();
    logic [NVEC-1:0] dl;
    for (int i = 0; i < NVEC; i++)
      dl[i] = (i >= NVEC/2) ? 1'b0 : (PRED[i] ^ ~PRED[NVEC-1-i]);
    return dl;
  endfunction

  localparam logic [NVEC-1:0] DELTA = mk_delta();

  function automatic logic force_node(input logic v, input logic [1:0] s);
    case (s)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      default: return v;
    endcase
  endfunction

  logic [NIN-1:0] xv;
  logic n0, n1, n2, n3, g_tree, g_pred, g_corr, gd_held;
  logic ra0, ra1, rb0, rb1;

  assign xv     = opnd ^ {NIN{chk_phase}};
  assign fn_out = LUT[xv*NOUT +: NOUT];

  assign n0     = force_node(fn_out[0] ^ fn_out[1], stuck_sel[1:0]);
  assign n1     = force_node(fn_out[2] ^ fn_out[3], stuck_sel[3:2]);
  assign n2     = force_node(fn_out[4] ^ fn_out[5], stuck_sel[5:4]);
  assign n3     = force_node(n0 ^ n1, stuck_sel[7:6]);
  assign g_tree = force_node(n3 ^ n2, stuck_sel[9:8]);

  assign g_pred = PRED[xv];
  assign g_corr = DELTA[xv] ^ g_tree;

  assign ra0 = g_tree;
  assign ra1 = ~g_pred;
  assign rb0 = chk_phase ? gd_held : 1'b0;
  assign rb1 = chk_phase ? g_corr  : 1'b1;

  assign err0 = (ra0 & rb0) | (ra1 & rb1);
  assign err1 = (ra0 & rb1) | (ra1 & rb0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_phase <= 1'b0;
      gd_held   <= 1'b0;
    end else begin
      chk_phase <= ~chk_phase;
      if (!chk_phase) gd_held <= g_corr;
    end
  end

  logic no_force;
  assign no_force = ~((stuck_sel[0] ^ stuck_sel[1]) | (stuck_sel[2] ^ stuck_sel[3]) |
                      (stuck_sel[4] ^ stuck_sel[5]) | (stuck_sel[6] ^ stuck_sel[7]) |
                      (stuck_sel[8] ^ stuck_sel[9]));

  // R2
  phase_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_phase |=> chk_phase);
  // R2
  phase_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_phase |=> !chk_phase);
  // R4
  fault_free_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (no_force && (!chk_phase || ($stable(opnd) && $past(no_force)))) |-> (err0 != err1));
  // R5
  parity_mismatch_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g_tree != g_pred) |-> (err0 == err1));
  // R6
  selfdual_violation_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_phase && (gd_held == g_corr)) |-> (err0 == err1));
  // R6
  held_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_phase |-> (gd_held == $past(g_corr)));
endmodule

// File: tb/test_dual_sign_ced.sv
module test_dual_sign_ced;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] opnd = '0;
  logic [9:0] stuck_sel = '0;
  logic [5:0] fn_out;
  logic       chk_phase, err0, err1;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dual_sign_ced i_dual_sign_ced (
    .clk(clk), .rst_n(rst_n), .opnd(opnd), .stuck_sel(stuck_sel),
    .fn_out(fn_out), .chk_phase(chk_phase), .err0(err0), .err1(err1));

  // {operand, expected function output}
  localparam logic [9:0] VEC [16] = '{
    {4'd0, 6'h2b}, {4'd1, 6'h11}, {4'd2, 6'h3c}, {4'd3, 6'h05},
    {4'd4, 6'h27}, {4'd5, 6'h1a}, {4'd6, 6'h30}, {4'd7, 6'h0e},
    {4'd8, 6'h19}, {4'd9, 6'h33}, {4'd10, 6'h06}, {4'd11, 6'h2d},
    {4'd12, 6'h14}, {4'd13, 6'h3f}, {4'd14, 6'h08}, {4'd15, 6'h21}};

  function automatic logic frc(input logic v, input logic [1:0] s);
    return (s == 2'b01) ? 1'b0 : (s == 2'b10) ? 1'b1 : v;
  endfunction

  function automatic logic tree_m(input int i, input logic [9:0] fs);
    logic [5:0] y;
    logic a, b, c, e;
    y = VEC[i][5:0];
    a = frc(y[0] ^ y[1], fs[1:0]);
    b = frc(y[2] ^ y[3], fs[3:2]);
    c = frc(y[4] ^ y[5], fs[5:4]);
    e = frc(a ^ b, fs[7:6]);
    return frc(e ^ c, fs[9:8]);
  endfunction

  function automatic logic par_m(input int i);
    return ^VEC[i][5:0];
  endfunction

  function automatic logic gd_m(input int i, input logic [9:0] fs);
    logic dl;
    dl = (i >= 8) ? 1'b0 : (par_m(i) ^ ~par_m(15 - i));
    return dl ^ tree_m(i, fs);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R8 phase in reset", chk_phase, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R2 phase after reset", chk_phase, 0);

    // fault-free exhaustive walk over the table
    for (int i = 0; i < 16; i++) begin
      logic h;
      opnd = VEC[i][9:6];
      stuck_sel = '0;
      #1;
      chk("R1 phase0 output", fn_out, VEC[i][5:0]);
      chk("R4 phase0 rails", {err0, err1}, {~par_m(i), par_m(i)});
      h = gd_m(i, '0);
      @(negedge clk);
      #1;
      chk("R2 phase toggles", chk_phase, 1);
      chk("R1 phase1 output", fn_out, VEC[15 - i][5:0]);
      chk("R4 phase1 rails", {err0, err1}, {~(par_m(15 - i) ^ h), par_m(15 - i) ^ h});
      @(negedge clk);
    end

    // alternative no-force encoding 11
    opnd = 4'd6;
    stuck_sel = 10'h3ff;
    #1 chk("R3 code 11 unforced", err0 ^ err1, 1);
    @(negedge clk);
    #1 chk("R3 code 11 unforced phase1", err0 ^ err1, 1);
    @(negedge clk);

    // forced nodes, every pair
    for (int node = 0; node < 5; node++) begin
      for (int sa = 1; sa <= 2; sa++) begin
        int det;
        det = 0;
        for (int i = 0; i < 16; i++) begin
          logic e0, e1;
          logic [9:0] fs;
          fs = 10'(sa) << (2 * node);
          opnd = VEC[i][9:6];
          stuck_sel = fs;
          e0 = tree_m(i, fs) != par_m(i);
          e1 = (tree_m(15 - i, fs) != par_m(15 - i)) || (gd_m(i, fs) == gd_m(15 - i, fs));
          #1;
          // R5 R7: phase 0 flags only a parity mismatch
          chk("R5 R7 phase0 detect", err0 == err1, e0);
          if (err0 == err1) det++;
          @(negedge clk);
          #1;
          // R5 R6: phase 1 flags parity mismatch or equal corrected parities
          chk("R5 R6 phase1 detect", err0 == err1, e1);
          if (err0 == err1) det++;
          @(negedge clk);
        end
        $display("node %0d force %0d: %0d of 32 vectors detected", node, sa - 1, det);
      end
    end

    // reset in the middle of a pair
    stuck_sel = '0;
    opnd = 4'd3;
    @(negedge clk);
    #1 chk("R2 mid pair phase", chk_phase, 1);
    rst_n = 1'b0;
    @(negedge clk);
    #1 chk("R8 reset returns phase0", chk_phase, 0);
    rst_n = 1'b1;
    chk("R1 after reset output", fn_out, VEC[3][5:0]);
    @(negedge clk);
    #1 chk("R2 phase1 after reset", chk_phase, 1);
    chk("R4 rails after reset", err0 ^ err1, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule